// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits in the outbound path of a link controller. It rewrites bus addresses into link-side addresses using a small set of programmable windows. Each window has a 64-bit match value, a 64-bit remap value, a 64-bit mask and a 32-bit action word. Software programs these through a write-only 32-bit register port.

A request enters through a valid/ready handshake with a 64-bit address and a bypass flag. One cycle later the block presents one of two results:
- On a hit, the translated address, the action word of the hitting window, a hit flag and the window index.
- On a miss, the untouched address with the default action word.

Translation can be switched off globally with a control input. Programmed-I/O requests carry their own routing and can skip the lookup through the bypass flag.

Top module: `addr_win_xlat`

## Requirements
- R1: After reset `rsp_valid_o` is 0, `req_ready_o` is 1, every window is disabled and the default action word is 0.
- R2: Window n has a 0x20-byte register block at 0x4C00 + 0x20·n. Within a block the offsets are: match low 0x00, match high 0x04, remap low 0x08, remap high 0x0C, mask low 0x10, mask high 0x14, action 0x18. The default action register is at 0x4CFC. Writes to addresses outside 0x4C00..0x4CFF change nothing.
- R3: Bit 0 of match low enables the window. A window with that bit clear never hits.
- R4: An address hits an enabled window when it equals the match value in every bit where the mask is 1. Mask bits [15:0] always read as 0, whatever is written to them, and match bit 0 takes no part in the comparison.
- R5: On a hit, the output address takes the remap value in the mask-covered bits and the input address elsewhere. The window's action word leaves unchanged. Its bits [3:0] hold the transaction type: 0x0 memory, 0x4 I/O, 0x8 config type 0, 0x9 config type 1, 0xC message. Bits [31:24] hold the function number.
- R6: When several enabled windows hit, the lowest-numbered one is used and its index appears on `rsp_win_o`.
- R7: On a miss, the output address equals the input address, `rsp_hit_o` is 0 and the action is the default action word.
- R8: While `xlat_en_i` is 0, every accepted request is treated as a miss.
- R9: A request with `req_bypass_i` set is treated as a miss, regardless of the windows.
- R10: A request accepted at a clock edge is presented on the next cycle. `req_ready_o` is 1 when the output slot is empty or being drained. While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, the outputs hold.
- R11: A request accepted in the same cycle as a register write uses the configuration from before the write. Requests accepted later use the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xlat_en_i | input | 1 | Global enable for window translation |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 16 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_addr_i | input | 64 | Request bus address |
| req_bypass_i | input | 1 | Skip window lookup (programmed I/O) |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Result ready |
| rsp_addr_o | output | 64 | Translated address |
| rsp_action_o | output | 32 | Selected action word |
| rsp_hit_o | output | 1 | A window hit |
| rsp_win_o | output | 3 | Index of the hitting window |

## Verification
A register write and a request acceptance can land on the same clock edge, and the request must see the old window contents. The bench provokes this by driving a write to a window's remap-high register in the same cycle as a request that hits that window. The result must carry the remap value from before the write, and a follow-up request must carry the new one. Output stalls coinciding with a new request are also exercised: the request must stay unaccepted until the held result drains.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  parameter int unsigned ADDR_W = 64;
  parameter int unsigned DATA_W = 32;

  localparam logic [4:0] OFF_MATCH_LO = 5'h00;
  localparam logic [4:0] OFF_MATCH_HI = 5'h04;
  localparam logic [4:0] OFF_REMAP_LO = 5'h08;
  localparam logic [4:0] OFF_REMAP_HI = 5'h0C;
  localparam logic [4:0] OFF_MASK_LO  = 5'h10;
  localparam logic [4:0] OFF_MASK_HI  = 5'h14;
  localparam logic [4:0] OFF_ACTION   = 5'h18;
  localparam logic [4:0] OFF_DEFAULT  = 5'h1C;

  typedef enum logic [3:0] {
    XT_MEM  = 4'h0,
    XT_IO   = 4'h4,
    XT_CFG0 = 4'h8,
    XT_CFG1 = 4'h9,
    XT_MSG  = 4'hC
  } xact_type_e;

  typedef struct packed {
    logic [ADDR_W-1:0] match;
    logic [ADDR_W-1:0] remap;
    logic [ADDR_W-1:0] mask;
    logic [DATA_W-1:0] action;
  } win_cfg_t;
endpackage

// File: rtl/awx_regfile.sv
module awx_regfile
  import addr_win_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned REG_AW    = 16,
  parameter int unsigned WIN_BASE  = 32'h4C00,
  parameter int unsigned MASK_ZERO = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output win_cfg_t          cfg_o [NUM_WIN],
  output logic [DATA_W-1:0] dflt_act_o
);
  localparam int unsigned STRIDE  = 32;
  localparam int unsigned WIN_END = WIN_BASE + NUM_WIN * STRIDE;
  localparam int unsigned LAST    = NUM_WIN - 1;
  localparam logic [DATA_W-1:0] LO_KEEP = ~((DATA_W'(1) << MASK_ZERO) - DATA_W'(1));

  logic              in_range;
  logic [REG_AW-1:0] rel;
  logic [4:0]        off;
  logic [REG_AW-6:0] widx;

  assign in_range = (32'(addr_i) >= WIN_BASE) && (32'(addr_i) < WIN_END);
  assign rel      = addr_i - REG_AW'(WIN_BASE);
  assign off      = rel[4:0];
  assign widx     = rel[REG_AW-1:5];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic              sel_w;
    logic [ADDR_W-1:0] match_q, remap_q, mask_q;
    logic [DATA_W-1:0] action_q;

    assign sel_w = we_i && in_range && (32'(widx) == w);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        match_q  <= '0;
        remap_q  <= '0;
        mask_q   <= '0;
        action_q <= '0;
      end else if (sel_w) begin
        case (off)
          OFF_MATCH_LO: match_q[DATA_W-1:0]      <= wdata_i;
          OFF_MATCH_HI: match_q[ADDR_W-1:DATA_W] <= wdata_i;
          OFF_REMAP_LO: remap_q[DATA_W-1:0]      <= wdata_i;
          OFF_REMAP_HI: remap_q[ADDR_W-1:DATA_W] <= wdata_i;
          OFF_MASK_LO:  mask_q[DATA_W-1:0]       <= wdata_i & LO_KEEP;
          OFF_MASK_HI:  mask_q[ADDR_W-1:DATA_W]  <= wdata_i;
          OFF_ACTION:   action_q                 <= wdata_i;
          default: ;
        endcase
      end
    end

    assign cfg_o[w] = '{match: match_q, remap: remap_q, mask: mask_q, action: action_q};
  end

  // default action lives in the unused slot of the last window block
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dflt_act_o <= '0;
    end else if (we_i && in_range && (32'(widx) == LAST) && (off == OFF_DEFAULT)) begin
      dflt_act_o <= wdata_i;
    end
  end
endmodule

// File: rtl/awx_lookup.sv
module awx_lookup
  import addr_win_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  win_cfg_t          cfg_i [NUM_WIN],
  input  logic [DATA_W-1:0] dflt_act_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] act_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] CMP_KEEP = ~ADDR_W'(1);

  logic [NUM_WIN-1:0] hit_vec;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign hit_vec[w] = cfg_i[w].match[0] &&
                        (((addr_i ^ cfg_i[w].match) & cfg_i[w].mask & CMP_KEEP) == '0);
  end

  logic             any;
  logic [IDX_W-1:0] sel;

  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        any = 1'b1;
        sel = IDX_W'(w);
      end
    end
  end

  win_cfg_t cur;
  assign cur = cfg_i[sel];

  always_comb begin
    if (en_i && any) begin
      addr_o = (cur.remap & cur.mask) | (addr_i & ~cur.mask);
      act_o  = cur.action;
      hit_o  = 1'b1;
      idx_o  = sel;
    end else begin
      addr_o = addr_i;
      act_o  = dflt_act_i;
      hit_o  = 1'b0;
      idx_o  = '0;
    end
  end
endmodule

// File: rtl/addr_win_xlat.sv
module addr_win_xlat
  import addr_win_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned REG_AW    = 16,
  parameter int unsigned WIN_BASE  = 32'h4C00,
  parameter int unsigned MASK_ZERO = 16,
  localparam int unsigned IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xlat_en_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_bypass_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [DATA_W-1:0] rsp_action_o,
  output logic              rsp_hit_o,
  output logic [IDX_W-1:0]  rsp_win_o
);
  win_cfg_t          cfg [NUM_WIN];
  logic [DATA_W-1:0] dflt_act;

  awx_regfile #(
    .NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .WIN_BASE(WIN_BASE), .MASK_ZERO(MASK_ZERO)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cfg_o(cfg), .dflt_act_o(dflt_act)
  );

  logic [ADDR_W-1:0] lk_addr;
  logic [DATA_W-1:0] lk_act;
  logic              lk_hit;
  logic [IDX_W-1:0]  lk_idx;

  awx_lookup #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_lookup (
    .addr_i(req_addr_i), .en_i(xlat_en_i && !req_bypass_i),
    .cfg_i(cfg), .dflt_act_i(dflt_act),
    .addr_o(lk_addr), .act_o(lk_act), .hit_o(lk_hit), .idx_o(lk_idx)
  );

  logic fire;
  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign fire        = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_addr_o   <= '0;
      rsp_action_o <= '0;
      rsp_hit_o    <= 1'b0;
      rsp_win_o    <= '0;
    end else begin
      if (req_ready_o) rsp_valid_o <= req_valid_i;
      if (fire) begin
        rsp_addr_o   <= lk_addr;
        rsp_action_o <= lk_act;
        rsp_hit_o    <= lk_hit;
        rsp_win_o    <= lk_idx;
      end
    end
  end
endmodule

// File: rtl/awx_checker.sv
module awx_checker #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LOW_BITS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              xlat_en_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_bypass_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [ADDR_W-1:0] rsp_addr_o,
  input logic [DATA_W-1:0] rsp_action_o,
  input logic              rsp_hit_o
);
  assert_accept_lat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o);

  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_addr_o) &&
                                    $stable(rsp_action_o) && $stable(rsp_hit_o));

  assert_low_bits_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_addr_o[LOW_BITS-1:0] == $past(req_addr_i[LOW_BITS-1:0]));

  assert_bypass_miss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_bypass_i |=> !rsp_hit_o && rsp_addr_o == $past(req_addr_i));

  assert_disabled_miss_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !xlat_en_i |=> !rsp_hit_o && rsp_addr_o == $past(req_addr_i));
endmodule

bind addr_win_xlat awx_checker #(.LOW_BITS(MASK_ZERO)) u_awx_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .xlat_en_i(xlat_en_i),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
  .req_bypass_i(req_bypass_i), .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
  .rsp_addr_o(rsp_addr_o), .rsp_action_o(rsp_action_o), .rsp_hit_o(rsp_hit_o)
);

// File: tb/sim_addr_win_xlat.sv
`timescale 1ns/1ps
module sim_addr_win_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlat_en = 1'b1;
  logic        we = 1'b0;
  logic [15:0] waddr = '0;
  logic [31:0] wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        req_bypass = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_addr;
  logic [31:0] rsp_action;
  logic        rsp_hit;
  logic [2:0]  rsp_win;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  addr_win_xlat u0 (
    .clk_i(clk), .rst_ni(rst_n), .xlat_en_i(xlat_en),
    .reg_we_i(we), .reg_addr_i(waddr), .reg_wdata_i(wdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_bypass_i(req_bypass), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_addr_o(rsp_addr), .rsp_action_o(rsp_action), .rsp_hit_o(rsp_hit),
    .rsp_win_o(rsp_win)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_win(input int w, input logic [63:0] m, input logic [63:0] r,
                         input logic [63:0] k, input logic [31:0] act);
    logic [15:0] b;
    b = 16'h4C00 + 16'(w * 32);
    wr(b + 16'h04, m[63:32]);
    wr(b + 16'h08, r[31:0]);
    wr(b + 16'h0C, r[63:32]);
    wr(b + 16'h10, k[31:0]);
    wr(b + 16'h14, k[63:32]);
    wr(b + 16'h18, act);
    wr(b + 16'h00, m[31:0]);
  endtask

  task automatic xact(input string req, input logic [63:0] a, input logic byp,
                      input logic [63:0] ea, input logic [31:0] eact,
                      input logic ehit, input int ewin);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_bypass = byp;
    @(negedge clk);
    req_valid = 1'b0; req_bypass = 1'b0;
    chk({req, " valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " addr"}, rsp_addr, ea);
    chk({req, " action"}, 64'(rsp_action), 64'(eact));
    chk({req, " hit"}, 64'(rsp_hit), 64'(ehit));
    if (ehit) chk({req, " win"}, 64'(rsp_win), 64'(ewin));
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", 64'(rsp_valid), 64'd0);
    chk("R1 ready after reset", 64'(req_ready), 64'd1);
    xact("R1 R7 miss with reset default", 64'h0000_0001_2003_4567, 1'b0,
         64'h0000_0001_2003_4567, 32'h0, 1'b0, 0);
  endtask

  task automatic t_basic;
    set_win(0, 64'h0000_0001_2000_0001, 64'h0000_0000_4000_0000,
            64'hFFFF_FFFF_FFF0_0000, 32'h4);
    xact("R2 R5 win0 hit io", 64'h0000_0001_2003_4567, 1'b0,
         64'h0000_0000_4003_4567, 32'h4, 1'b1, 0);
    xact("R4 R7 outside mask miss", 64'h0000_0001_2103_4567, 1'b0,
         64'h0000_0001_2103_4567, 32'h0, 1'b0, 0);
  endtask

  task automatic t_mask_low;
    set_win(1, 64'h0000_0005_0000_0001, 64'h0000_0006_0000_0000,
            64'hFFFF_FFFF_FFFF_FFFF, 32'h8);
    xact("R4 low mask bits ignored", 64'h0000_0005_0000_ABCD, 1'b0,
         64'h0000_0006_0000_ABCD, 32'h8, 1'b1, 1);
    xact("R4 bit16 compared", 64'h0000_0005_0001_0000, 1'b0,
         64'h0000_0005_0001_0000, 32'h0, 1'b0, 0);
  endtask

  task automatic t_priority;
    set_win(2, 64'h0000_0001_2000_0001, 64'h0000_0000_7000_0000,
            64'hFFFF_FFFF_FF00_0000, 32'h9);
    xact("R6 overlap lowest wins", 64'h0000_0001_2003_4567, 1'b0,
         64'h0000_0000_4003_4567, 32'h4, 1'b1, 0);
    xact("R6 only win2", 64'h0000_0001_2053_0000, 1'b0,
         64'h0000_0000_7053_0000, 32'h9, 1'b1, 2);
  endtask

  task automatic t_last_win;
    set_win(7, 64'h0000_000A_0000_0001, 64'h0000_000B_0000_0000,
            64'hFFFF_FFFF_FFFF_0000, 32'h1280_000C);
    xact("R2 R5 win7 action verbatim", 64'h0000_000A_0000_1234, 1'b0,
         64'h0000_000B_0000_1234, 32'h1280_000C, 1'b1, 7);
  endtask

  task automatic t_enable;
    wr(16'h4C00, 32'h2000_0000);
    xact("R3 disabled win0 skipped", 64'h0000_0001_2003_4567, 1'b0,
         64'h0000_0000_7003_4567, 32'h9, 1'b1, 2);
  endtask

  task automatic t_default;
    wr(16'h4CFC, 32'h0000_000C);
    xact("R7 default action", 64'h0000_0003_0000_0000, 1'b0,
         64'h0000_0003_0000_0000, 32'hC, 1'b0, 0);
  endtask

  task automatic t_global_off;
    @(negedge clk); xlat_en = 1'b0;
    xact("R8 translation off", 64'h0000_0001_2053_0000, 1'b0,
         64'h0000_0001_2053_0000, 32'hC, 1'b0, 0);
    @(negedge clk); xlat_en = 1'b1;
  endtask

  task automatic t_bypass;
    xact("R9 bypass", 64'h0000_0001_2053_0000, 1'b1,
         64'h0000_0001_2053_0000, 32'hC, 1'b0, 0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 64'h0000_000A_0000_1234;
    @(negedge clk);
    chk("R10 first valid", 64'(rsp_valid), 64'd1);
    chk("R10 ready low when full", 64'(req_ready), 64'd0);
    chk("R10 first addr", rsp_addr, 64'h0000_000B_0000_1234);
    req_addr = 64'h0000_0005_0000_ABCD;
    @(negedge clk);
    chk("R10 held addr", rsp_addr, 64'h0000_000B_0000_1234);
    chk("R10 held win", 64'(rsp_win), 64'd7);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 second valid", 64'(rsp_valid), 64'd1);
    chk("R10 second addr", rsp_addr, 64'h0000_0006_0000_ABCD);
    @(negedge clk);
    chk("R10 drained", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 64'h0000_0005_0000_0123;
    we = 1'b1; waddr = 16'h4C2C; wdata = 32'h9;
    @(negedge clk);
    req_valid = 1'b0; we = 1'b0;
    chk("R11 old config used", rsp_addr, 64'h0000_0006_0000_0123);
    xact("R11 new config used", 64'h0000_0005_0000_0123, 1'b0,
         64'h0000_0009_0000_0123, 32'h8, 1'b1, 1);
    wr(16'h0C2C, 32'h3);
    xact("R2 out-of-range write ignored", 64'h0000_0005_0000_0123, 1'b0,
         64'h0000_0009_0000_0123, 32'h8, 1'b1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mask_low();
    t_priority();
    t_last_win();
    t_enable();
    t_default();
    t_global_off();
    t_bypass();
    t_stall();
    t_same_cycle();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule